// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block picks which of the output queues that share one port may send its next packet. Each queue holds a service level from 0 to 9, written through a small configuration interface. Levels 1 to 8 turn into an eight-bit participation mask. A 3-bit round counter walks through the eight mask bits. A queue takes part in a round only when its mask bit for that round is set, so a queue at level 8 is served eight times as often as one at level 1. Level 0 takes part in no round. Level 9 places a queue in the strict-priority group. That group must be a contiguous run of queues starting at queue 0. Any of its queues that has data wins before any weighted queue, and a lower index wins over a higher one.

The scheduler issues one grant at a time: an index with a valid flag. The grant is held until the consumer accepts it, and the cycle after the accept is always idle. While no grant is pending, weighted queues are scanned round-robin starting after the last weighted winner. When no eligible queue remains before the last queue, the round counter steps and the scan restarts from queue 0. Configuration writes land only while no grant is pending. A malformed strict-priority group or a level above 9 raises an error flag.

Top module: `wrr_queue_sched`

## Requirements
- R1: After reset gnt_valid is 0, cfg_err is 0, every queue's level is 0, the round counter is 0 and the weighted scan starts at queue 0.
- R2: Levels map to round masks as 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF, and 9 or more→0xFF. A weighted queue is eligible in round r only when bit r of its mask is 1.
- R3: A queue at level 0 is never granted.
- R4: A queue at level 9 is strict-priority. While idle, the lowest-indexed non-empty strict-priority queue is granted ahead of all weighted queues, and this leaves the round counter and the scan position unchanged.
- R5: The set of level-9 queues must be empty or exactly queues 0..k-1. Any other layout raises cfg_err, and while it persists no grant is issued and the scheduler state does not move.
- R6: A level value of 10 to 15 raises cfg_err, and the queue is scheduled as a weighted queue with mask 0xFF.
- R7: While idle with no strict-priority grant, the grant goes to the lowest index i at or after the scan position with i non-empty, not strict-priority and eligible in the current round. The scan position then becomes i+1.
- R8: When no queue qualifies under R7, no grant is issued in that cycle, the round counter advances by one modulo 8 and the scan position returns to queue 0.
- R9: A grant is registered one clock after it is picked. gnt_valid and gnt_queue hold while gnt_accept is 0. An accept clears gnt_valid on the next edge, and the cycle after an accept never carries a grant.
- R10: A configuration write presented while a grant is pending is dropped.
- R11: cfg_err reflects the stored levels with one cycle of latency: it updates on the edge after the one that stored the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one queue's level |
| cfg_queue | input | QW | Queue index being written |
| cfg_level | input | 4 | Level value, 0..8 weighted, 9 strict, above 9 invalid |
| q_nonempty | input | NQ | One bit per queue, 1 when the queue holds a packet |
| gnt_accept | input | 1 | Consumer takes the pending grant |
| gnt_valid | output | 1 | A grant is pending |
| gnt_queue | output | QW | Index of the granted queue |
| cfg_err | output | 1 | Stored levels are invalid (bad strict layout or level above 9) |

## Verification
The bench builds the scheduler with four queues. This makes every one of the sixteen strict-priority layouts and every level value from 0 to 15 reachable in a few thousand cycles. A nested sweep over two queues' levels, paired with pseudo-random non-empty and accept patterns, drives every mask bit in every round. It also exercises scan wrap-around from the last queue, rounds in which no queue qualifies, and grants held for many cycles. A cycle-level model built from the requirements predicts the grant, its index and the error flag on every cycle.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    localparam int ROUNDS = 8;
    localparam int RND_W  = $clog2(ROUNDS);
    localparam int LVL_W  = 4;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [ROUNDS-1:0] rmask_t;

    localparam lvl_t LVL_STRICT  = lvl_t'(9);
    localparam lvl_t LVL_TOP_WGT = lvl_t'(8);

    // Participation bits spaced evenly over the eight rounds.
    function automatic rmask_t lvl_to_mask(lvl_t lvl);
        rmask_t m;
        case (lvl)
            lvl_t'(0): m = 8'h00;
            lvl_t'(1): m = 8'h01;
            lvl_t'(2): m = 8'h11;
            lvl_t'(3): m = 8'h49;
            lvl_t'(4): m = 8'h55;
            lvl_t'(5): m = 8'h57;
            lvl_t'(6): m = 8'h77;
            lvl_t'(7): m = 8'h7F;
            default:   m = 8'hFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/wrr_level_table.sv
module wrr_level_table
    import wrr_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [QW-1:0]    wr_idx,
    input  lvl_t             wr_lvl,
    input  logic [RND_W-1:0] round,
    output logic [NQ-1:0]    strict_vec,
    output logic [NQ-1:0]    round_en,
    output logic             layout_bad,
    output logic             level_bad
);
    lvl_t lvl_q [NQ];
    lvl_t lvl_d [NQ];
    logic [NQ-1:0] over_lvl;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            lvl_d[i] = lvl_q[i];
        end
        if (wr_en) begin
            lvl_d[wr_idx] = wr_lvl;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NQ; i++) begin
            if (!rst_n) lvl_q[i] <= '0;
            else        lvl_q[i] <= lvl_d[i];
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        rmask_t mask;
        assign mask          = lvl_to_mask(lvl_q[g]);
        assign strict_vec[g] = (lvl_q[g] == LVL_STRICT);
        assign over_lvl[g]   = (lvl_q[g] > LVL_STRICT);
        assign round_en[g]   = mask[round];
    end

    // A valid strict group is a run of ones from bit 0: adding one clears it.
    assign layout_bad = |(strict_vec & (strict_vec + NQ'(1)));
    assign level_bad  = |over_lvl;
endmodule

// File: rtl/wrr_first_pick.sv
module wrr_first_pick #(
    parameter int NQ = 16,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NQ-1:0] req,
    input  logic [QW:0]   from,
    output logic          hit,
    output logic [QW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i] && (i >= int'(from))) begin
                hit = 1'b1;
                idx = QW'(i);
            end
        end
    end
endmodule

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched
    import wrr_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_queue,
    input  logic [3:0]    cfg_level,
    input  logic [NQ-1:0] q_nonempty,
    input  logic          gnt_accept,
    output logic          gnt_valid,
    output logic [QW-1:0] gnt_queue,
    output logic          cfg_err
);
    typedef struct packed {
        logic             gv;
        logic [QW-1:0]    gidx;
        logic [QW:0]      start;
        logic [RND_W-1:0] round;
        logic             err;
    } st_t;

    st_t s_q, s_d;

    logic [NQ-1:0] strict_vec, round_en, s_req, w_req;
    logic          layout_bad, level_bad, s_hit, w_hit;
    logic [QW-1:0] s_idx, w_idx;

    wrr_level_table #(.NQ(NQ)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we && !s_q.gv),
        .wr_idx     (cfg_queue),
        .wr_lvl     (lvl_t'(cfg_level)),
        .round      (s_q.round),
        .strict_vec (strict_vec),
        .round_en   (round_en),
        .layout_bad (layout_bad),
        .level_bad  (level_bad)
    );

    assign s_req = q_nonempty & strict_vec;
    assign w_req = q_nonempty & ~strict_vec & round_en;

    wrr_first_pick #(.NQ(NQ)) u_strict_pick (
        .req  (s_req),
        .from ('0),
        .hit  (s_hit),
        .idx  (s_idx)
    );

    wrr_first_pick #(.NQ(NQ)) u_weight_pick (
        .req  (w_req),
        .from (s_q.start),
        .hit  (w_hit),
        .idx  (w_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = layout_bad | level_bad;
        if (s_q.gv) begin
            if (gnt_accept) s_d.gv = 1'b0;
        end else if (!layout_bad) begin
            if (s_hit) begin
                s_d.gv   = 1'b1;
                s_d.gidx = s_idx;
            end else if (w_hit) begin
                s_d.gv    = 1'b1;
                s_d.gidx  = w_idx;
                s_d.start = {1'b0, w_idx} + (QW+1)'(1);
            end else begin
                s_d.round = s_q.round + RND_W'(1);
                s_d.start = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gnt_valid = s_q.gv;
    assign gnt_queue = s_q.gidx;
    assign cfg_err   = s_q.err;

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv && !gnt_accept |=> s_q.gv && $stable(s_q.gidx));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv && gnt_accept |=> !s_q.gv);

    p_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.gv) |-> (($past(q_nonempty) >> s_q.gidx) & NQ'(1)) != '0);

    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        layout_bad && !s_q.gv |=> !s_q.gv && $stable(s_q.round) && $stable(s_q.start));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.round) |-> s_q.start == '0);
endmodule

// File: tb/wrr_queue_sched_test.sv
`timescale 1ns/1ps
module wrr_queue_sched_test;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [QW-1:0] cfg_queue = '0;
    logic [3:0]    cfg_level = '0;
    logic [NQ-1:0] q_nonempty = '0;
    logic          gnt_accept = 1'b0;
    logic          gnt_valid;
    logic [QW-1:0] gnt_queue;
    logic          cfg_err;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // model state
    int m_lvl [NQ];
    int m_gv, m_gidx, m_start, m_round, m_err;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    wrr_queue_sched #(.NQ(NQ)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_queue(cfg_queue),
        .cfg_level(cfg_level), .q_nonempty(q_nonempty), .gnt_accept(gnt_accept),
        .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .cfg_err(cfg_err)
    );

    // R2 mask values
    function automatic int exp_mask(int lvl);
        case (lvl)
            0: return 'h00;
            1: return 'h01;
            2: return 'h11;
            3: return 'h49;
            4: return 'h55;
            5: return 'h57;
            6: return 'h77;
            7: return 'h7F;
            default: return 'hFF;
        endcase
    endfunction

    function automatic logic [15:0] next_lfsr(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic compare();
        bit bad;
        checks++;
        bad = (int'(gnt_valid) != m_gv) || (int'(cfg_err) != m_err) ||
              (m_gv != 0 && int'(gnt_queue) != m_gidx);
        if (bad) begin
            fails++;
            $display("FAIL %s t=%0t: valid=%0d queue=%0d err=%0d expected valid=%0d queue=%0d err=%0d",
                     cur_req, $time, gnt_valid, gnt_queue, cfg_err, m_gv, m_gidx, m_err);
        end
    endtask

    // One clock: compare, drive, predict, advance.
    task automatic tick(bit we, int widx, int wlvl, logic [NQ-1:0] ne, bit acc);
        int sv, n_gv, n_gidx, n_start, n_round, found;
        bit lay_bad, lvl_bad;
        compare();
        cfg_we = we; cfg_queue = QW'(widx); cfg_level = 4'(wlvl);
        q_nonempty = ne; gnt_accept = acc;
        sv = 0; lvl_bad = 0;
        for (int i = 0; i < NQ; i++) begin
            if (m_lvl[i] == 9) sv |= (1 << i);
            if (m_lvl[i] > 9) lvl_bad = 1;
        end
        lay_bad = ((sv & (sv + 1)) & ((1 << NQ) - 1)) != 0;   // R5
        n_gv = m_gv; n_gidx = m_gidx; n_start = m_start; n_round = m_round;
        if (m_gv != 0) begin
            if (acc) n_gv = 0;                                  // R9
        end else begin
            if (!lay_bad) begin
                found = -1;
                for (int i = NQ - 1; i >= 0; i--)               // R4
                    if (sv[i] && ne[i]) found = i;
                if (found >= 0) begin
                    n_gv = 1; n_gidx = found;
                end else begin
                    for (int i = NQ - 1; i >= m_start; i--)     // R7
                        if (ne[i] && !sv[i] && ((exp_mask(m_lvl[i]) >> m_round) & 1) != 0)
                            found = i;
                    if (found >= 0) begin
                        n_gv = 1; n_gidx = found; n_start = found + 1;
                    end else begin
                        n_round = (m_round + 1) % 8;            // R8
                        n_start = 0;
                    end
                end
            end
        end
        @(posedge clk);
        if (m_gv == 0 && we) m_lvl[widx] = wlvl;                // R10
        m_err = (lay_bad || lvl_bad) ? 1 : 0;                   // R11
        m_gv = n_gv; m_gidx = n_gidx; m_start = n_start; m_round = n_round;
        @(negedge clk);
    endtask

    task automatic set_levels(int l0, int l1, int l2, int l3);
        int lv [NQ];
        lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
        tick(0, 0, 0, '0, 1);
        tick(0, 0, 0, '0, 1);
        for (int i = 0; i < NQ; i++) tick(1, i, lv[i], '0, 1);
    endtask

    task automatic traffic(int n, bit rand_acc);
        for (int k = 0; k < n; k++) begin
            lfsr = next_lfsr(lfsr);
            tick(0, 0, 0, lfsr[3:0] | lfsr[7:4], rand_acc ? lfsr[8] | lfsr[9] : 1'b1);
        end
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) m_lvl[i] = 0;
        m_gv = 0; m_gidx = 0; m_start = 0; m_round = 0; m_err = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R3 level 0 queues never granted
        cur_req = "R1";
        tick(0, 0, 0, '1, 1);
        cur_req = "R3";
        for (int k = 0; k < 16; k++) tick(0, 0, 0, '1, 1);

        // R2 R3 R6 R7 R8 R11: level sweep on two queues
        cur_req = "R2/R3/R6/R7/R8/R11";
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 11; b++) begin
                set_levels(a == 9 ? 8 : a, 1, 0, b == 9 ? 3 : b);
                traffic(20, 1'b1);
                for (int k = 0; k < 10; k++) tick(0, 0, 0, '1, 1);
            end

        // R4 R5: every strict-priority layout
        cur_req = "R4/R5";
        for (int p = 0; p < 16; p++) begin
            set_levels(p[0] ? 9 : 4, p[1] ? 9 : 6, p[2] ? 9 : 2, p[3] ? 9 : 7);
            traffic(30, 1'b1);
            for (int k = 0; k < 6; k++) tick(0, 0, 0, 4'b1010, 1);
        end

        // R9 R10: long holds, writes attempted while a grant is pending
        cur_req = "R9/R10";
        set_levels(3, 5, 8, 2);
        tick(0, 0, 0, '1, 0);
        tick(0, 0, 0, '1, 0);
        for (int k = 0; k < 8; k++) tick(1, k % NQ, 9 + (k % 2) * 5, '1, 0);
        tick(0, 0, 0, '1, 1);
        traffic(60, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule